// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block carries out the state side effects of a processor taking an exception and returning from one. Each cycle it looks at a vector of exception requests. When at least one is raised, it picks the most urgent one and stores the current status word in the saved-status bank of the target mode. It stores the supplied return address in that mode's banked link register. It then produces a new status word and the exception's vector address. The new status word has the mode field switched, the 32-bit instruction state forced, and the interrupt masks applied.

On a return request it produces the status word held in the saved-status bank of the mode the processor is in. The status register itself lives in the surrounding datapath: the block presents the next value together with a write strobe. The datapath feeds the current value back on `curPsr`.

The saved status and link register of the current mode are read out at all times. Fetch, decode and memory belong elsewhere. Status word layout, from high to low bits: flags [31:27], IT[1:0] [26:25], J [24], reserved [23:20], GE [19:16], IT[7:2] [15:10], E [9], A [8], I [7], F [6], T [5], mode [4:0].

Top module: `exc_entry_seq`

## Requirements
- R1: While `rstN` is low and after its release, `entryDone`, `retDone` and `psrWe` are 0 and `newPc` is 0 until the first request is accepted.
- R2: On entry, the saved-status bank of the target mode receives the value of `curPsr` sampled with the request. It is read back on `savedPsr` whenever `curPsr[4:0]` names that mode.
- R3: On entry, `psrNext[4:0]` is the target mode: reset and supervisor call go to 10011, undefined instruction goes to 11011, both aborts go to 10111, IRQ goes to 10010 and FIQ goes to 10001.
- R4: On entry, T (bit 5), J (bit 24) and both IT fields (bits 26:25 and 15:10) are cleared in `psrNext`. Flags, GE, E, A and reserved bits are copied from `curPsr`.
- R5: On entry, I (bit 7) is always set. F (bit 6) is set on reset and FIQ entry and is otherwise copied.
- R6: On entry, the target mode's banked link register receives `retAddr`. It is read back on `linkAddr` whenever `curPsr[4:0]` names that mode.
- R7: On entry, `newPc` is `VEC_BASE` plus the slot offset: reset 0x00, undefined 0x04, supervisor call 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C.
- R8: Request bits are: 0 reset, 1 undefined, 2 supervisor call, 3 prefetch abort, 4 data abort, 5 IRQ, 6 FIQ. When several are raised together, the first in this order wins: reset, data abort, FIQ, IRQ, prefetch abort, undefined, supervisor call.
- R9: `entryDone` and `psrWe` are high in the clock cycle after a request is sampled, and low after a cycle with no request and no return.
- R10: A return request in an exception mode makes `psrNext` equal to that mode's saved status, with `retDone` and `psrWe` high for one cycle.
- R11: A return request in user (10000) or system (11111) mode has no effect: `retDone` and `psrWe` stay low.
- R12: When an entry request and a return request come together, only the entry is performed.
- R13: An entry writes only the target mode's banks; the other modes' saved status and link registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| excReq | input | 7 | Exception request bits (see R8) |
| excRet | input | 1 | Exception return request |
| curPsr | input | 32 | Current status word from the datapath |
| retAddr | input | ADDR_W | Return address to bank on entry |
| psrNext | output | 32 | Status word to write into the current status register |
| psrWe | output | 1 | Write strobe for `psrNext` |
| newPc | output | ADDR_W | Vector address of the last accepted exception |
| entryDone | output | 1 | Entry completed this cycle |
| retDone | output | 1 | Return completed this cycle |
| savedPsr | output | 32 | Saved status of the mode named by `curPsr` (0 in user/system) |
| linkAddr | output | ADDR_W | Banked link register of the mode named by `curPsr` (0 in user/system) |

## Verification
The bound checker checks the following on every cycle:
- the entry strobe has a request one cycle earlier;
- the return strobe has a return, with no entry request, one cycle earlier;
- an entry always yields an IRQ mask and a cleared T and J;
- a reset request always yields a set F;
- a return in user mode never completes;
- a combined entry and return always resolves to entry only.

The bench's scenarios must show the following:
- the exact vector addresses and the priority choice over all 127 request combinations;
- bit-exact copying of the other status fields;
- that each banked saved status and link register holds what was stored there and is untouched by entries into other modes.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int NUM_REQ  = 7;
  localparam int NUM_BANK = 5;
  localparam int PSR_W    = 32;

  // request bit positions
  localparam int RQ_RESET = 0;
  localparam int RQ_UNDEF = 1;
  localparam int RQ_SVC   = 2;
  localparam int RQ_PABT  = 3;
  localparam int RQ_DABT  = 4;
  localparam int RQ_IRQ   = 5;
  localparam int RQ_FIQ   = 6;

  // mode encodings
  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  // status word bit positions
  localparam int PSR_T = 5;
  localparam int PSR_F = 6;
  localparam int PSR_I = 7;
  localparam int PSR_J = 24;

  // kind value equals vector slot index (offset / 4)
  typedef enum logic [2:0] {
    EK_RESET = 3'd0,
    EK_UNDEF = 3'd1,
    EK_SVC   = 3'd2,
    EK_PABT  = 3'd3,
    EK_DABT  = 3'd4,
    EK_IRQ   = 3'd6,
    EK_FIQ   = 3'd7
  } excKind_e;

  typedef struct packed {
    logic       hit;
    logic [2:0] idx;
  } bankSel_t;

  typedef struct packed {
    logic       entryGo;
    logic       retGo;
    excKind_e   kind;
    logic [4:0] tgtMode;
    logic [2:0] tgtBank;
    logic       maskFiq;
    logic [2:0] retBank;
  } seqStrobe_t;

  function automatic bankSel_t modeToBank(input logic [4:0] m);
    bankSel_t s;
    s.hit = 1'b1;
    s.idx = 3'd0;
    case (m)
      MODE_FIQ: s.idx = 3'd0;
      MODE_IRQ: s.idx = 3'd1;
      MODE_SVC: s.idx = 3'd2;
      MODE_ABT: s.idx = 3'd3;
      MODE_UND: s.idx = 3'd4;
      default:  s.hit = 1'b0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
(
  input  logic [NUM_REQ-1:0] excReq,
  input  logic               excRet,
  input  logic [4:0]         curMode,
  output seqStrobe_t         strobe
);

  excKind_e kindSel;
  bankSel_t curBank;
  bankSel_t tgtSel;
  logic     anyReq;

  assign anyReq  = |excReq;
  assign curBank = modeToBank(curMode);

  // fixed priority pick
  always_comb begin
    if (excReq[RQ_RESET])     kindSel = EK_RESET;
    else if (excReq[RQ_DABT]) kindSel = EK_DABT;
    else if (excReq[RQ_FIQ])  kindSel = EK_FIQ;
    else if (excReq[RQ_IRQ])  kindSel = EK_IRQ;
    else if (excReq[RQ_PABT]) kindSel = EK_PABT;
    else if (excReq[RQ_UNDEF]) kindSel = EK_UNDEF;
    else                      kindSel = EK_SVC;
  end

  logic [4:0] modeSel;
  always_comb begin
    case (kindSel)
      EK_UNDEF:         modeSel = MODE_UND;
      EK_PABT, EK_DABT: modeSel = MODE_ABT;
      EK_IRQ:           modeSel = MODE_IRQ;
      EK_FIQ:           modeSel = MODE_FIQ;
      default:          modeSel = MODE_SVC;
    endcase
  end

  assign tgtSel = modeToBank(modeSel);

  always_comb begin
    strobe         = '0;
    strobe.entryGo = anyReq;
    strobe.kind    = kindSel;
    strobe.tgtMode = modeSel;
    strobe.tgtBank = tgtSel.idx;
    strobe.maskFiq = (kindSel == EK_RESET) || (kindSel == EK_FIQ);
    strobe.retGo   = excRet && !anyReq && curBank.hit;
    strobe.retBank = curBank.idx;
  end

endmodule

// File: rtl/exc_seq_dp.sv
module exc_seq_dp
  import exc_seq_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [PSR_W-1:0]  curPsr,
  input  logic [ADDR_W-1:0] retAddr,
  output logic [PSR_W-1:0]  psrNext,
  output logic              psrWe,
  output logic [ADDR_W-1:0] newPc,
  output logic              entryDone,
  output logic              retDone,
  output logic [PSR_W-1:0]  savedPsr,
  output logic [ADDR_W-1:0] linkAddr
);

  logic [NUM_BANK-1:0][PSR_W-1:0]  spsrAll;
  logic [NUM_BANK-1:0][ADDR_W-1:0] lrAll;

  // banked saved status and link registers
  for (genvar g = 0; g < NUM_BANK; g++) begin : gBank
    logic [PSR_W-1:0]  spsrR;
    logic [ADDR_W-1:0] lrR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        spsrR <= '0;
        lrR   <= '0;
      end else if (strobe.entryGo && (strobe.tgtBank == 3'(g))) begin
        spsrR <= curPsr;
        lrR   <= retAddr;
      end
    end
    assign spsrAll[g] = spsrR;
    assign lrAll[g]   = lrR;
  end

  // status word on entry
  logic [PSR_W-1:0] entryPsr;
  always_comb begin
    entryPsr          = curPsr;
    entryPsr[4:0]     = strobe.tgtMode;
    entryPsr[PSR_T]   = 1'b0;
    entryPsr[PSR_J]   = 1'b0;
    entryPsr[26:25]   = 2'b00;
    entryPsr[15:10]   = 6'b0;
    entryPsr[PSR_I]   = 1'b1;
    if (strobe.maskFiq) entryPsr[PSR_F] = 1'b1;
  end

  logic [ADDR_W-1:0] vecAddr;
  assign vecAddr = VEC_BASE + ADDR_W'({strobe.kind, 2'b00});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psrNext   <= '0;
      psrWe     <= 1'b0;
      newPc     <= '0;
      entryDone <= 1'b0;
      retDone   <= 1'b0;
    end else begin
      entryDone <= strobe.entryGo;
      retDone   <= strobe.retGo;
      psrWe     <= strobe.entryGo || strobe.retGo;
      if (strobe.entryGo) begin
        psrNext <= entryPsr;
        newPc   <= vecAddr;
      end else if (strobe.retGo) begin
        psrNext <= spsrAll[strobe.retBank];
      end
    end
  end

  // read port for the mode currently in force
  bankSel_t rdSel;
  assign rdSel    = modeToBank(curPsr[4:0]);
  assign savedPsr = rdSel.hit ? spsrAll[rdSel.idx] : '0;
  assign linkAddr = rdSel.hit ? lrAll[rdSel.idx] : '0;

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [6:0]        excReq,
  input  logic              excRet,
  input  logic [31:0]       curPsr,
  input  logic [ADDR_W-1:0] retAddr,
  output logic [31:0]       psrNext,
  output logic              psrWe,
  output logic [ADDR_W-1:0] newPc,
  output logic              entryDone,
  output logic              retDone,
  output logic [31:0]       savedPsr,
  output logic [ADDR_W-1:0] linkAddr
);

  seqStrobe_t strobe;

  exc_seq_ctrl u_ctrl (
    .excReq  (excReq),
    .excRet  (excRet),
    .curMode (curPsr[4:0]),
    .strobe  (strobe)
  );

  exc_seq_dp #(
    .ADDR_W   (ADDR_W),
    .VEC_BASE (VEC_BASE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .curPsr    (curPsr),
    .retAddr   (retAddr),
    .psrNext   (psrNext),
    .psrWe     (psrWe),
    .newPc     (newPc),
    .entryDone (entryDone),
    .retDone   (retDone),
    .savedPsr  (savedPsr),
    .linkAddr  (linkAddr)
  );

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic [6:0]  excReq,
  input logic        excRet,
  input logic [31:0] curPsr,
  input logic [31:0] psrNext,
  input logic        psrWe,
  input logic        entryDone,
  input logic        retDone
);

  a_r9_entry_has_request: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |-> ($past(excReq) != 7'd0));

  a_r9_entry_writes: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |-> psrWe);

  a_r10_ret_has_request: assert property (@(posedge clk) disable iff (!rstN)
    retDone |-> ($past(excRet) && ($past(excReq) == 7'd0)));

  a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |-> psrNext[7]);

  a_r5_fiq_on_reset: assert property (@(posedge clk) disable iff (!rstN)
    excReq[0] |=> psrNext[6]);

  a_r4_arm_state: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |-> (!psrNext[5] && !psrNext[24]));

  a_r11_user_ret_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (excRet && (excReq == 7'd0) && (curPsr[4:0] == 5'b10000)) |=> !retDone);

  a_r12_entry_wins: assert property (@(posedge clk) disable iff (!rstN)
    (excRet && (excReq != 7'd0)) |=> (entryDone && !retDone));

endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .excReq    (excReq),
  .excRet    (excRet),
  .curPsr    (curPsr),
  .psrNext   (psrNext),
  .psrWe     (psrWe),
  .entryDone (entryDone),
  .retDone   (retDone)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

  localparam logic [31:0] BASE = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  excReq = '0;
  logic        excRet = 1'b0;
  logic [31:0] curPsr = 32'h0000_0010;
  logic [31:0] retAddr = '0;
  logic [31:0] psrNext;
  logic        psrWe;
  logic [31:0] newPc;
  logic        entryDone;
  logic        retDone;
  logic [31:0] savedPsr;
  logic [31:0] linkAddr;

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  logic [31:0] mSpsr [32];
  logic [31:0] mLr   [32];

  always #2 clk = ~clk;

  exc_entry_seq #(.ADDR_W(32), .VEC_BASE(BASE)) u_exc_entry_seq (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excRet(excRet),
    .curPsr(curPsr), .retAddr(retAddr), .psrNext(psrNext), .psrWe(psrWe),
    .newPc(newPc), .entryDone(entryDone), .retDone(retDone),
    .savedPsr(savedPsr), .linkAddr(linkAddr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FIAL-free:%s", "");
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // winner slot per requirement R8 priority
  function automatic int pickSlot(input logic [6:0] r);
    if (r[0]) return 0;
    if (r[4]) return 4;
    if (r[6]) return 7;
    if (r[5]) return 6;
    if (r[3]) return 3;
    if (r[1]) return 1;
    return 2;
  endfunction

  function automatic logic [4:0] slotMode(input int s);
    case (s)
      1: return 5'b11011;
      3, 4: return 5'b10111;
      6: return 5'b10010;
      7: return 5'b10001;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] expPsr(input int s, input logic [31:0] p);
    logic [31:0] e;
    e = p;
    e[4:0] = slotMode(s);
    e[5] = 1'b0;
    e[24] = 1'b0;
    e[26:25] = 2'b0;
    e[15:10] = 6'b0;
    e[7] = 1'b1;
    if (s == 0 || s == 7) e[6] = 1'b1;
    return e;
  endfunction

  // drive a request, then check the entry outputs one cycle later
  task automatic doEntry(input logic [6:0] req, input logic [31:0] psr, input logic [31:0] ra, input bit full);
    int s;
    logic [31:0] e;
    s = pickSlot(req);
    e = expPsr(s, psr);
    @(negedge clk);
    excReq = req; curPsr = psr; retAddr = ra; excRet = 1'b0;
    @(negedge clk);
    excReq = '0;
    mSpsr[slotMode(s)] = psr;
    mLr[slotMode(s)] = ra;
    check("R8 vector choice", newPc, BASE + 32'(s * 4));
    check("R3 mode field", {27'b0, psrNext[4:0]}, {27'b0, slotMode(s)});
    if (full) begin
      check("R9 entryDone", {31'b0, entryDone}, 32'd1);
      check("R9 psrWe", {31'b0, psrWe}, 32'd1);
      check("R7 newPc", newPc, BASE + 32'(s * 4));
      check("R4 state bits", {29'b0, psrNext[24], psrNext[5], |{psrNext[26:25], psrNext[15:10]}}, 32'd0);
      check("R5 mask bits", {30'b0, psrNext[7], psrNext[6]}, {30'b0, e[7], e[6]});
      check("R4 full status", psrNext, e);
    end
    curPsr = psrNext;
  endtask

  logic [31:0] pats [5];

  initial begin
    pats[0] = 32'h0000_0010;
    pats[1] = 32'hF70F_FC30;
    pats[2] = 32'h8005_0213;
    pats[3] = 32'h600A_0190;
    pats[4] = 32'h0000_0051;
    for (int i = 0; i < 32; i++) begin mSpsr[i] = '0; mLr[i] = '0; end

    #1;
    check("R1 entryDone in reset", {31'b0, entryDone}, 32'd0);
    check("R1 psrWe in reset", {31'b0, psrWe}, 32'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 retDone", {31'b0, retDone}, 32'd0);
    check("R1 newPc", newPc, 32'd0);
    check("R1 entryDone", {31'b0, entryDone}, 32'd0);

    // single requests under several status patterns
    for (int p = 0; p < 5; p++) begin
      for (int b = 0; b < 7; b++) begin
        logic [31:0] ra;
        ra = 32'h1000_0000 + 32'(p * 256) + 32'(b * 4);
        doEntry(7'(1 << b), pats[p], ra, 1'b1);
        @(negedge clk);
        check("R9 entryDone drops", {31'b0, entryDone}, 32'd0);
        check("R9 psrWe drops", {31'b0, psrWe}, 32'd0);
        check("R2 saved status", savedPsr, pats[p]);
        check("R6 link register", linkAddr, ra);
        excRet = 1'b1;
        @(negedge clk);
        excRet = 1'b0;
        check("R10 retDone", {31'b0, retDone}, 32'd1);
        check("R10 psrWe", {31'b0, psrWe}, 32'd1);
        check("R10 restored status", psrNext, pats[p]);
      end
    end

    // every request combination
    for (int r = 1; r < 128; r++) begin
      doEntry(7'(r), 32'h0000_001F, 32'h2000_0000 + 32'(r * 4), 1'b0);
    end

    // returns in user and system mode are ignored
    @(negedge clk);
    curPsr = 32'h0000_0010; excRet = 1'b1;
    @(negedge clk);
    check("R11 user retDone", {31'b0, retDone}, 32'd0);
    check("R11 user psrWe", {31'b0, psrWe}, 32'd0);
    curPsr = 32'hA000_001F;
    @(negedge clk);
    excRet = 1'b0;
    check("R11 system retDone", {31'b0, retDone}, 32'd0);
    check("R11 system psrWe", {31'b0, psrWe}, 32'd0);

    // entry and return together
    curPsr = 32'h4000_0012; excRet = 1'b1; excReq = 7'b010_0000; retAddr = 32'h3000_0040;
    @(negedge clk);
    excRet = 1'b0; excReq = '0;
    mSpsr[5'b10010] = 32'h4000_0012;
    mLr[5'b10010] = 32'h3000_0040;
    check("R12 entryDone", {31'b0, entryDone}, 32'd1);
    check("R12 retDone", {31'b0, retDone}, 32'd0);
    check("R12 status", psrNext, expPsr(6, 32'h4000_0012));
    check("R12 pc", newPc, BASE + 32'h18);

    // banks keep their own contents
    for (int m = 0; m < 5; m++) begin
      logic [4:0] md;
      case (m)
        0: md = 5'b10001;
        1: md = 5'b10010;
        2: md = 5'b10011;
        3: md = 5'b10111;
        default: md = 5'b11011;
      endcase
      curPsr = {27'b0, md};
      #1;
      check("R13 saved status bank", savedPsr, mSpsr[md]);
      check("R13 link bank", linkAddr, mLr[md]);
      @(negedge clk);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule